// File: doc/BRIEF.md
# Software Flow Control Engine for a Serial Port

This block adds automatic XON/XOFF handling to a byte-wide serial port. On the receive side it examines every character that the deserializer delivers and compares it against programmed flow codes. A matching stop code holds the transmitter. A matching resume code releases it. Flow codes are removed from the stream, and every other byte goes on to the receive buffer unchanged. On the transmit side it accepts stop and resume requests from the host or from the buffer watermark logic. It then places the matching flow code or codes in front of the next data byte whenever the transmitter reports idle.

There are two programmable code pairs. A receive selector and a transmit selector each pick the first pair, the second pair, or both. When both pairs are selected, a flow code is the two-byte sequence of first-pair code followed by second-pair code. An optional mode lets any received character release a hold. Two sticky notification bits record that a stop code was received and that a stop code was sent. An interrupt can be raised when a flow code is received.

Top module: `swflow_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `tx_hold`, `flow_flag`, `inject_valid`, `rx_out_valid` and `irq` are 0, `notify` is 0x00 and `iid` is 0x01. Any pending inject request is dropped.
- R2: With `fc_mode[1:0]`=2'b10 (first pair), a received byte equal to `xoff1` sets `tx_hold` and `flow_flag`, and a byte equal to `xon1` clears them. Both take effect one clock after the strobe, and neither byte appears on `rx_out_valid`.
- R3: With `fc_mode[1:0]`=2'b01 (second pair), only `xoff2`/`xon2` act as flow codes. A byte equal to `xoff1` passes through and leaves the hold unchanged.
- R4: With `fc_mode[1:0]`=2'b00, every received byte, flow codes included, appears on `rx_out_data` with `rx_out_valid` one clock after its strobe, and the hold is unchanged.
- R5: With `fc_mode[1:0]`=2'b11, the consecutive pair `xoff1`,`xoff2` sets the hold and the pair `xon1`,`xon2` clears it. All four bytes are consumed.
- R6: With `fc_mode[1:0]`=2'b11, if the byte after a held `xoff1`/`xon1` does not complete the pair, the held byte is output one clock after the breaking byte. The breaking byte (when not itself a first-pair code) is output one clock later, and the hold is unchanged. Received strobes are never in adjacent cycles.
- R7: With `any_resume`=1, any received byte other than a stop code releases the hold, and a non-flow byte still passes through. With `any_resume`=0, a non-flow byte leaves the hold set.
- R8: With `fc_mode[3:2]`=2'b10, a `req_xoff` pulse while `tx_idle`=1 produces a one-cycle `inject_valid` carrying `xoff1` two clocks after the request. At that point `notify` bit 4 (stop code sent) becomes 1.
- R9: With `fc_mode[3:2]`=2'b11, a request sends the first-pair code and then the second-pair code. The second byte is issued only one clock after `tx_idle` is seen high again, and `inject_valid` is never high in two adjacent cycles.
- R10: With `fc_mode[3:2]`=2'b00, inject requests are ignored: `inject_valid` stays 0 and `tx_hold` is not raised by them.
- R11: `tx_hold` is high while an inject request is pending or in progress, so the code goes ahead of data. An inject is still issued while a received stop code holds the transmitter.
- R12: `notify` bit 3 (stop code received) and bit 4 (stop code sent) are sticky. They stay set after the hold is released, and a `status_clr` pulse clears them.
- R13: With `irq_en`=1, a received flow code raises `irq` one clock later and `iid` reads 0x10. With `irq_en`=0, `irq` is 0 and `iid` reads 0x01. `status_clr` clears the pending cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_mode | input | 4 | [3:2] transmit pair select, [1:0] receive pair select (10 first, 01 second, 11 both, 00 off) |
| any_resume | input | 1 | Any received character releases a hold |
| irq_en | input | 1 | Enable interrupt on received flow code |
| xon1 | input | 8 | First-pair resume code |
| xon2 | input | 8 | Second-pair resume code |
| xoff1 | input | 8 | First-pair stop code |
| xoff2 | input | 8 | Second-pair stop code |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| req_xoff | input | 1 | Request to send a stop code |
| req_xon | input | 1 | Request to send a resume code |
| tx_idle | input | 1 | Transmitter can accept a byte |
| status_clr | input | 1 | Clear sticky notify bits and interrupt cause |
| rx_out_valid | output | 1 | Byte forwarded to receive buffer |
| rx_out_data | output | 8 | Forwarded byte |
| inject_valid | output | 1 | Flow code to transmit this cycle |
| inject_data | output | 8 | Flow code byte |
| tx_hold | output | 1 | Transmitter must not take data |
| flow_flag | output | 1 | Current stop-code hold state |
| notify | output | 8 | Bit 3 stop received, bit 4 stop sent (sticky) |
| irq | output | 1 | Interrupt request |
| iid | output | 8 | Interrupt identification, 0x10 flow code, 0x01 none |

## Verification
Every receive result falls one clock after the strobe: a passed byte, a consumed code, the hold, the sticky bits and the interrupt. The exception is the second byte released by a broken two-byte sequence, which comes out two clocks after its strobe. On the transmit side the first code appears two clocks after the request edge, and a second-pair code appears one clock after `tx_idle` returns. The bench changes inputs on falling edges and samples on the falling edge that follows exactly the number of rising edges these latencies need. That way each check lands in the cycle the result is due, and neither earlier nor later.

// File: rtl/swflow_pkg.sv
// Shared types and constants for the software flow control engine.
package swflow_pkg;
    // Pair selector encoding, used by both the receive and transmit fields.
    typedef enum logic [1:0] {
        PAIR_NONE = 2'b00,
        PAIR_TWO  = 2'b01,
        PAIR_ONE  = 2'b10,
        PAIR_BOTH = 2'b11
    } pair_sel_t;

    // Transmit injector sequencing states.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'b00,
        TX_GAP1  = 2'b01,
        TX_WAITB = 2'b10,
        TX_GAP2  = 2'b11
    } tx_state_t;

    localparam logic [7:0] IID_FLOWCHAR = 8'h10;
    localparam logic [7:0] IID_NONE     = 8'h01;
    localparam int NOTIFY_HOLD_BIT = 3;
    localparam int NOTIFY_SENT_BIT = 4;
endpackage

// File: rtl/swflow_rx_match.sv
// Receive matcher: compares incoming characters with the programmed flow
// codes, reports stop/resume events and forwards every other byte.
// Assumes received strobes are never in adjacent cycles, and that the
// receive selector changes only while the line is quiet.
module swflow_rx_match
    import swflow_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    rx_sel,
    input  logic [CW-1:0] xon1,
    input  logic [CW-1:0] xon2,
    input  logic [CW-1:0] xoff1,
    input  logic [CW-1:0] xoff2,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_data,
    output logic          out_valid,
    output logic [CW-1:0] out_data,
    output logic          evt_xoff,
    output logic          evt_xon
);
    logic          held_valid;
    logic          held_xoff;
    logic [CW-1:0] held_byte;
    logic          queue_valid;
    logic [CW-1:0] queue_byte;

    logic pass, release_held, start_xoff, start_xon, queue_new, seq_done;

    // Classify the current character according to the selected pair mode.
    always_comb begin
        evt_xoff     = 1'b0;
        evt_xon      = 1'b0;
        pass         = 1'b0;
        release_held = 1'b0;
        start_xoff   = 1'b0;
        start_xon    = 1'b0;
        queue_new    = 1'b0;
        seq_done     = 1'b0;
        if (rx_valid) begin
            case (pair_sel_t'(rx_sel))
                PAIR_ONE: begin
                    if (rx_data == xoff1)      evt_xoff = 1'b1;
                    else if (rx_data == xon1)  evt_xon  = 1'b1;
                    else                       pass     = 1'b1;
                end
                PAIR_TWO: begin
                    if (rx_data == xoff2)      evt_xoff = 1'b1;
                    else if (rx_data == xon2)  evt_xon  = 1'b1;
                    else                       pass     = 1'b1;
                end
                PAIR_BOTH: begin
                    if (held_valid && held_xoff && rx_data == xoff2) begin
                        evt_xoff = 1'b1;
                        seq_done = 1'b1;
                    end else if (held_valid && !held_xoff && rx_data == xon2) begin
                        evt_xon  = 1'b1;
                        seq_done = 1'b1;
                    end else begin
                        release_held = held_valid;
                        if (rx_data == xoff1)      start_xoff = 1'b1;
                        else if (rx_data == xon1)  start_xon  = 1'b1;
                        else if (held_valid)       queue_new  = 1'b1;
                        else                       pass       = 1'b1;
                    end
                end
                default: pass = 1'b1;
            endcase
        end
    end

    // Forward passed, released and queued bytes to the receive buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            queue_valid <= 1'b0;
            queue_byte  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (queue_valid) begin
                out_valid   <= 1'b1;
                out_data    <= queue_byte;
                queue_valid <= 1'b0;
            end
            if (pass) begin
                out_valid <= 1'b1;
                out_data  <= rx_data;
            end
            if (release_held) begin
                out_valid <= 1'b1;
                out_data  <= held_byte;
            end
            if (queue_new) begin
                queue_valid <= 1'b1;
                queue_byte  <= rx_data;
            end
        end
    end

    // Keep the first half of a two-byte flow sequence until it resolves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_valid <= 1'b0;
            held_xoff  <= 1'b0;
            held_byte  <= '0;
        end else if (start_xoff || start_xon) begin
            held_valid <= 1'b1;
            held_xoff  <= start_xoff;
            held_byte  <= rx_data;
        end else if (seq_done || release_held || pair_sel_t'(rx_sel) != PAIR_BOTH) begin
            held_valid <= 1'b0;
        end
    end

    // R6
    rx_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R2
    consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_xoff || evt_xon) |=> !out_valid);
    // R4
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sel == 2'b00) |=> (out_valid && out_data == $past(rx_data)));
endmodule

// File: rtl/swflow_tx_inject.sv
// Transmit injector: latches stop/resume requests and issues the selected
// flow code bytes whenever the transmitter reports idle, ahead of data.
// Assumes the transmitter drops tx_idle within one cycle of taking a byte.
module swflow_tx_inject
    import swflow_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    tx_sel,
    input  logic [CW-1:0] xon1,
    input  logic [CW-1:0] xon2,
    input  logic [CW-1:0] xoff1,
    input  logic [CW-1:0] xoff2,
    input  logic          req_xoff,
    input  logic          req_xon,
    input  logic          tx_idle,
    output logic          inject_valid,
    output logic [CW-1:0] inject_data,
    output logic          busy,
    output logic          sent_xoff
);
    tx_state_t     state;
    logic          pend_valid;
    logic          pend_xoff;
    logic          cur_xoff;
    logic          sel_on;
    logic          launch_a;
    logic          launch_b;
    logic [CW-1:0] first_byte;
    logic [CW-1:0] second_byte;

    // Decide launches and the bytes they carry.
    always_comb begin
        sel_on      = (pair_sel_t'(tx_sel) != PAIR_NONE);
        launch_a    = (state == TX_IDLE) && pend_valid && tx_idle && sel_on;
        launch_b    = (state == TX_WAITB) && tx_idle && sel_on;
        if (pair_sel_t'(tx_sel) == PAIR_TWO)
            first_byte = pend_xoff ? xoff2 : xon2;
        else
            first_byte = pend_xoff ? xoff1 : xon1;
        second_byte = cur_xoff ? xoff2 : xon2;
        sent_xoff   = (launch_a && pend_xoff && pair_sel_t'(tx_sel) != PAIR_BOTH)
                    || (launch_b && cur_xoff);
        busy        = pend_valid || (state != TX_IDLE);
    end

    // Latch requests; stop wins over resume, disabled mode drops them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_xoff  <= 1'b0;
        end else if (!sel_on) begin
            pend_valid <= 1'b0;
        end else if (req_xoff) begin
            pend_valid <= 1'b1;
            pend_xoff  <= 1'b1;
        end else if (req_xon) begin
            pend_valid <= 1'b1;
            pend_xoff  <= 1'b0;
        end else if (launch_a) begin
            pend_valid <= 1'b0;
        end
    end

    // Sequence one or two code bytes with a gap cycle after each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= TX_IDLE;
            cur_xoff     <= 1'b0;
            inject_valid <= 1'b0;
            inject_data  <= '0;
        end else begin
            inject_valid <= 1'b0;
            case (state)
                TX_IDLE: if (launch_a) begin
                    inject_valid <= 1'b1;
                    inject_data  <= first_byte;
                    cur_xoff     <= pend_xoff;
                    state        <= (pair_sel_t'(tx_sel) == PAIR_BOTH) ? TX_GAP1 : TX_GAP2;
                end
                TX_GAP1: state <= TX_WAITB;
                TX_WAITB: begin
                    if (launch_b) begin
                        inject_valid <= 1'b1;
                        inject_data  <= second_byte;
                        state        <= TX_GAP2;
                    end else if (!sel_on) begin
                        state <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R10
    tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sel == 2'b00) |=> !inject_valid);
    // R11
    tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inject_valid |-> $past(tx_idle));
    // R9
    tx_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inject_valid |=> !inject_valid);
endmodule

// File: rtl/swflow_status.sv
// Status and interrupt: keeps the transmit hold state, the sticky notify
// bits and the flow-code interrupt cause.
// Assumes event inputs are single-cycle pulses from the matcher and injector.
module swflow_status
    import swflow_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_xoff,
    input  logic       evt_xon,
    input  logic       rx_valid,
    input  logic       any_resume,
    input  logic       sent_xoff,
    input  logic       inject_busy,
    input  logic       status_clr,
    input  logic       irq_en,
    output logic       tx_hold,
    output logic       flow_flag,
    output logic [7:0] notify,
    output logic       irq,
    output logic [7:0] iid
);
    logic hold_q, stk_hold, stk_sent, cause_q, release_now;

    // Combine hold sources and format the status outputs.
    always_comb begin
        release_now = evt_xon || (any_resume && rx_valid && !evt_xoff);
        tx_hold     = hold_q || inject_busy;
        flow_flag   = hold_q;
        notify      = '0;
        notify[NOTIFY_HOLD_BIT] = stk_hold;
        notify[NOTIFY_SENT_BIT] = stk_sent;
        irq         = cause_q && irq_en;
        iid         = irq ? IID_FLOWCHAR : IID_NONE;
    end

    // Track the receive-driven hold level.
    always_ff @(posedge clk) begin
        if (!rst_n)           hold_q <= 1'b0;
        else if (evt_xoff)    hold_q <= 1'b1;
        else if (release_now) hold_q <= 1'b0;
    end

    // Sticky notify bits and interrupt cause; new events beat a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_hold <= 1'b0;
            stk_sent <= 1'b0;
            cause_q  <= 1'b0;
        end else begin
            if (status_clr) begin
                stk_hold <= 1'b0;
                stk_sent <= 1'b0;
                cause_q  <= 1'b0;
            end
            if (evt_xoff)            stk_hold <= 1'b1;
            if (sent_xoff)           stk_sent <= 1'b1;
            if (evt_xoff || evt_xon) cause_q  <= 1'b1;
        end
    end

    // R2
    hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_xoff |=> flow_flag);
    // R7
    any_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_resume && rx_valid && !evt_xoff) |=> !flow_flag);
    // R12
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (notify[NOTIFY_HOLD_BIT] && !status_clr) |=> notify[NOTIFY_HOLD_BIT]);
    // R13
    iid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (iid == IID_FLOWCHAR));
endmodule

// File: rtl/swflow_ctrl.sv
// Top of the software flow control engine: receive matcher, transmit
// injector and status/interrupt logic. Assumes one byte-wide serial port.
module swflow_ctrl
    import swflow_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    fc_mode,
    input  logic          any_resume,
    input  logic          irq_en,
    input  logic [CW-1:0] xon1,
    input  logic [CW-1:0] xon2,
    input  logic [CW-1:0] xoff1,
    input  logic [CW-1:0] xoff2,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_data,
    input  logic          req_xoff,
    input  logic          req_xon,
    input  logic          tx_idle,
    input  logic          status_clr,
    output logic          rx_out_valid,
    output logic [CW-1:0] rx_out_data,
    output logic          inject_valid,
    output logic [CW-1:0] inject_data,
    output logic          tx_hold,
    output logic          flow_flag,
    output logic [7:0]    notify,
    output logic          irq,
    output logic [7:0]    iid
);
    logic evt_xoff, evt_xon, sent_xoff, inject_busy;

    swflow_rx_match #(.CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_sel(fc_mode[1:0]),
        .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .out_valid(rx_out_valid), .out_data(rx_out_data),
        .evt_xoff(evt_xoff), .evt_xon(evt_xon)
    );

    swflow_tx_inject #(.CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_sel(fc_mode[3:2]),
        .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
        .req_xoff(req_xoff), .req_xon(req_xon), .tx_idle(tx_idle),
        .inject_valid(inject_valid), .inject_data(inject_data),
        .busy(inject_busy), .sent_xoff(sent_xoff)
    );

    swflow_status u_st (
        .clk(clk), .rst_n(rst_n), .evt_xoff(evt_xoff), .evt_xon(evt_xon),
        .rx_valid(rx_valid), .any_resume(any_resume), .sent_xoff(sent_xoff),
        .inject_busy(inject_busy), .status_clr(status_clr), .irq_en(irq_en),
        .tx_hold(tx_hold), .flow_flag(flow_flag), .notify(notify),
        .irq(irq), .iid(iid)
    );

    // R11
    inject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inject_valid |-> tx_hold);
endmodule

// File: tb/swflow_ctrl_test.sv
`timescale 1ns/1ps
module swflow_ctrl_test;
    localparam logic [7:0] C_XON1 = 8'h11, C_XOFF1 = 8'h13, C_XON2 = 8'h91, C_XOFF2 = 8'h93;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] fc_mode = 4'b0000;
    logic any_resume = 1'b0, irq_en = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic req_xoff = 1'b0, req_xon = 1'b0, tx_idle = 1'b0, status_clr = 1'b0;
    logic rx_out_valid, inject_valid, tx_hold, flow_flag, irq;
    logic [7:0] rx_out_data, inject_data, notify, iid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    swflow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fc_mode(fc_mode), .any_resume(any_resume),
        .irq_en(irq_en), .xon1(C_XON1), .xon2(C_XON2), .xoff1(C_XOFF1), .xoff2(C_XOFF2),
        .rx_valid(rx_valid), .rx_data(rx_data), .req_xoff(req_xoff), .req_xon(req_xon),
        .tx_idle(tx_idle), .status_clr(status_clr),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
        .inject_valid(inject_valid), .inject_data(inject_data),
        .tx_hold(tx_hold), .flow_flag(flow_flag), .notify(notify), .irq(irq), .iid(iid)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_xoff = 0; req_xon = 0; tx_idle = 0; status_clr = 0;
        rx_valid = 0; any_resume = 0; irq_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Strobe one character; returns one rising edge later.
    task automatic rx_send(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); status_clr = 1'b1;
        @(negedge clk); status_clr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 tx_hold", tx_hold, 0);
        chk("R1 flow_flag", flow_flag, 0);
        chk("R1 inject_valid", inject_valid, 0);
        chk("R1 rx_out_valid", rx_out_valid, 0);
        chk("R1 notify", notify, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 iid", iid, 8'h01);
    endtask

    task automatic t_rx_off();
        do_reset(); fc_mode = 4'b0000;
        rx_send(C_XOFF1);
        chk("R4 valid", rx_out_valid, 1);
        chk("R4 data", rx_out_data, C_XOFF1);
        chk("R4 hold", tx_hold, 0);
    endtask

    task automatic t_rx_pair1();
        do_reset(); fc_mode = 4'b0010;
        rx_send(8'h41);
        chk("R2 pass valid", rx_out_valid, 1);
        chk("R2 pass data", rx_out_data, 8'h41);
        rx_send(C_XOFF1);
        chk("R2 xoff consumed", rx_out_valid, 0);
        chk("R2 tx_hold", tx_hold, 1);
        chk("R2 flow_flag", flow_flag, 1);
        chk("R2 notify", notify[3], 1);
        rx_send(C_XON1);
        chk("R2 xon consumed", rx_out_valid, 0);
        chk("R2 released", tx_hold, 0);
    endtask

    task automatic t_rx_pair2();
        do_reset(); fc_mode = 4'b0001;
        rx_send(C_XOFF1);
        chk("R3 xoff1 passes", rx_out_valid, 1);
        chk("R3 xoff1 data", rx_out_data, C_XOFF1);
        chk("R3 no hold", tx_hold, 0);
        rx_send(C_XOFF2);
        chk("R3 xoff2 hold", tx_hold, 1);
        chk("R3 xoff2 consumed", rx_out_valid, 0);
        rx_send(C_XON2);
        chk("R3 xon2 release", tx_hold, 0);
    endtask

    task automatic t_rx_both();
        do_reset(); fc_mode = 4'b0011;
        rx_send(C_XOFF1);
        chk("R5 first half held", rx_out_valid, 0);
        chk("R5 no hold yet", tx_hold, 0);
        rx_send(C_XOFF2);
        chk("R5 hold", tx_hold, 1);
        chk("R5 consumed", rx_out_valid, 0);
        rx_send(C_XON1);
        chk("R5 xon1 held", rx_out_valid, 0);
        rx_send(C_XON2);
        chk("R5 release", tx_hold, 0);
        chk("R5 xon consumed", rx_out_valid, 0);
    endtask

    task automatic t_rx_break();
        do_reset(); fc_mode = 4'b0011;
        rx_send(C_XOFF1);
        chk("R6 held", rx_out_valid, 0);
        rx_send(8'h55);
        chk("R6 held out valid", rx_out_valid, 1);
        chk("R6 held out data", rx_out_data, C_XOFF1);
        @(negedge clk);
        chk("R6 breaker valid", rx_out_valid, 1);
        chk("R6 breaker data", rx_out_data, 8'h55);
        chk("R6 no hold", tx_hold, 0);
    endtask

    task automatic t_any();
        do_reset(); fc_mode = 4'b0010;
        rx_send(C_XOFF1);
        rx_send(8'h33);
        chk("R7 no release when off", tx_hold, 1);
        any_resume = 1'b1;
        rx_send(8'h34);
        chk("R7 released", tx_hold, 0);
        chk("R7 byte passes", rx_out_valid, 1);
        chk("R7 byte data", rx_out_data, 8'h34);
    endtask

    task automatic t_tx_single();
        do_reset(); fc_mode = 4'b1000;
        @(negedge clk); tx_idle = 1'b1; req_xoff = 1'b1;
        @(negedge clk); req_xoff = 1'b0;
        chk("R11 pending holds data", tx_hold, 1);
        chk("R8 not yet", inject_valid, 0);
        @(negedge clk);
        chk("R8 inject", inject_valid, 1);
        chk("R8 data", inject_data, C_XOFF1);
        chk("R8 sent bit", notify[4], 1);
        tx_idle = 1'b0;
        @(negedge clk);
        chk("R8 one cycle", inject_valid, 0);
        @(negedge clk);
        chk("R8 hold dropped", tx_hold, 0);
    endtask

    task automatic t_tx_both();
        do_reset(); fc_mode = 4'b1100;
        @(negedge clk); tx_idle = 1'b1; req_xon = 1'b1;
        @(negedge clk); req_xon = 1'b0;
        @(negedge clk);
        chk("R9 first valid", inject_valid, 1);
        chk("R9 first data", inject_data, C_XON1);
        tx_idle = 1'b0;
        @(negedge clk);
        chk("R9 gap", inject_valid, 0);
        @(negedge clk);
        chk("R9 waits idle", inject_valid, 0);
        chk("R9 still held", tx_hold, 1);
        tx_idle = 1'b1;
        @(negedge clk);
        chk("R9 second valid", inject_valid, 1);
        chk("R9 second data", inject_data, C_XON2);
        chk("R9 resume not stop", notify[4], 0);
        tx_idle = 1'b0;
        @(negedge clk);
        chk("R9 done", inject_valid, 0);
        chk("R9 hold dropped", tx_hold, 0);
    endtask

    task automatic t_tx_off();
        logic seen;
        do_reset(); fc_mode = 4'b0000; seen = 1'b0;
        @(negedge clk); tx_idle = 1'b1; req_xoff = 1'b1;
        @(negedge clk); req_xoff = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (inject_valid || tx_hold) seen = 1'b1;
            @(negedge clk);
        end
        chk("R10 ignored", seen, 0);
        chk("R10 no sent bit", notify[4], 0);
    endtask

    task automatic t_tx_prio();
        do_reset(); fc_mode = 4'b1010;
        rx_send(C_XOFF1);
        chk("R11 xoff held", tx_hold, 1);
        @(negedge clk); tx_idle = 1'b1; req_xon = 1'b1;
        @(negedge clk); req_xon = 1'b0;
        @(negedge clk);
        chk("R11 inject while held", inject_valid, 1);
        chk("R11 inject data", inject_data, C_XON1);
        chk("R11 data still held", tx_hold, 1);
        tx_idle = 1'b0;
    endtask

    task automatic t_sticky();
        do_reset(); fc_mode = 4'b0010;
        rx_send(C_XOFF1);
        rx_send(C_XON1);
        chk("R12 flag cleared", flow_flag, 0);
        chk("R12 sticky kept", notify, 8'h08);
        pulse_clr();
        chk("R12 cleared", notify, 8'h00);
    endtask

    task automatic t_irq();
        do_reset(); fc_mode = 4'b0010; irq_en = 1'b1;
        rx_send(C_XON1);
        chk("R13 irq", irq, 1);
        chk("R13 iid", iid, 8'h10);
        pulse_clr();
        chk("R13 irq cleared", irq, 0);
        chk("R13 iid none", iid, 8'h01);
        irq_en = 1'b0;
        rx_send(C_XOFF1);
        chk("R13 masked irq", irq, 0);
        chk("R13 masked iid", iid, 8'h01);
    endtask

    initial begin
        t_reset();
        t_rx_off();
        t_rx_pair1();
        t_rx_pair2();
        t_rx_both();
        t_rx_break();
        t_any();
        t_tx_single();
        t_tx_both();
        t_tx_off();
        t_tx_prio();
        t_sticky();
        t_irq();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule